// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block holds the time of day and the calendar date as seven byte-wide BCD registers: seconds, minutes, hours, day of week, date, month (with a century flag in its top bit) and year. A fractional-second enable feeds an internal divider. Every `FRAC_PER_SEC` enable pulses, the divider yields one second step, and that step ripples through the chain. Month lengths and leap Februaries are handled, and the hours byte can be kept in either a 24-hour or a 12-hour layout with a PM flag.

A host bus controller writes the registers one byte at a time. A write to the seconds register also restarts the sub-second divider, so a freshly set time gets a full second before its first step. Reads never see the live counters. A snapshot strobe, which the bus controller raises at the start of each transfer or when its register pointer wraps, copies all seven live registers into a shadow set. Reads are then served from that shadow set while the live chain keeps counting.

Top module: `rtc_calendar_chain`

## Requirements
- R1: Seconds (address 0) and minutes (address 1) count in BCD from 00 to 59. The units digit carries into the tens digit after 9, and a wrap from 59 to 00 advances the next field.
- R2: With hours bit 6 clear, the hours register counts in BCD from 00 to 23, with bits 5:4 holding the tens digit. A wrap from 23 to 00 is midnight.
- R3: With hours bit 6 set, bits 4:0 hold a BCD hour from 01 to 12 and bit 5 is PM (1 = PM). The sequence is 11 AM → 12 PM → 01 PM, and 11 PM → 12 AM. Midnight is the step into 12 AM.
- R4: At midnight the date advances. It wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R5: February ends at 29 when the BCD year is a multiple of four (00 included) and at 28 otherwise.
- R6: The month (bits 4:0 of address 5) wraps from 12 to 01 and advances the year (address 6). A year wrap from 99 to 00 toggles the century flag, bit 7 of address 5.
- R7: Day of week (address 3) advances at midnight through 1..7 and wraps from 7 to 1.
- R8: After reset both the live and the shadow registers hold seconds 00, minutes 00, hours 00 (24-hour mode), day 1, date 01, month 01 with century 0, and year 00.
- R9: The chain advances by exactly one second on the clock edge that takes the `FRAC_PER_SEC`-th `frac_en` pulse since the divider was last cleared. A write to address 0 clears the divider, and the chain does not change without a step or a write.
- R10: A write to address 0..6 stores `wr_data` ANDed with its mask: 7F, 7F, 7F, 07, 3F, 9F, FF. A write takes priority over a second step in the same cycle, and that step is discarded. A write to address 7 changes nothing.
- R11: `snap` copies the live registers, as they stood before that edge, into the shadow set. Without `snap` the shadow set holds its value. `rd_data` shows shadow register `rd_addr` combinationally, and address 7 reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frac_en | input | 1 | Single-cycle fractional-second enable feeding the divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data byte |
| snap | input | 1 | Copy live registers into the shadow set |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Shadow register contents at `rd_addr` |

## Verification
A behavioural model steps decoded integers and checks the shadow reads on every clock. Directed scenarios then load times just before each kind of rollover:
- a full year-end cascade with century flip, which separates the carry from each field into the next;
- leap and common Februaries plus a 30-day month, which separate the month-length rules;
- the 12-hour noon and midnight crossings, which separate PM toggling from date advance.

Divider-phase patterns target specific ordering rules:
- a seconds write mid-second, which exposes a missing divider clear;
- a write aligned with a step, which exposes wrong write/step priority;
- runs with `snap` held low, which show whether the shadow set is decoupled from the live chain.

// File: rtl/rtc_cal_pkg.sv
// Package: shared constants and helpers for the BCD clock-calendar chain.
// Assumes all stored fields are BCD bytes and the register file has seven entries.
package rtc_cal_pkg;

    localparam int NUM_REGS = 7;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_SEC  = 3'd0,
        ADR_MIN  = 3'd1,
        ADR_HOUR = 3'd2,
        ADR_DOW  = 3'd3,
        ADR_DATE = 3'd4,
        ADR_MON  = 3'd5,
        ADR_YEAR = 3'd6
    } cal_reg_e;

    // Bits kept on a write to each register; all others read back as zero.
    function automatic logic [7:0] wr_mask(input int idx);
        case (idx)
            0, 1, 2: wr_mask = 8'h7F;
            3:       wr_mask = 8'h07;
            4:       wr_mask = 8'h3F;
            5:       wr_mask = 8'h9F;
            default: wr_mask = 8'hFF;
        endcase
    endfunction

    // Power-on contents of each register.
    function automatic logic [7:0] reset_val(input int idx);
        case (idx)
            3, 4, 5: reset_val = 8'h01;
            default: reset_val = 8'h00;
        endcase
    endfunction

    // Adds one to a two-digit BCD byte (no range check).
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] == 4'd9) bcd_inc8 = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc8 = {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
// Sub-second divider: counts frac_en pulses and raises sec_step on the pulse
// that completes a second. A clear restarts the count and suppresses the step.
// Assumes FRAC_PER_SEC >= 2.
module rtc_subsec_div #(
    parameter int FRAC_PER_SEC = 32768,
    parameter int CNT_W        = (FRAC_PER_SEC > 1) ? $clog2(FRAC_PER_SEC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frac_en,
    input  logic             clear,
    output logic             sec_step,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAC_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step when the final fractional pulse of a second arrives and no clear is pending.
    assign sec_step = frac_en && (cnt_q == LAST) && !clear;
    assign cnt_o    = cnt_q;

    // Fraction counter with clear priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (frac_en) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/rtc_bcd_field_next.sv
// Next-value logic for a plain BCD field with a fixed range LO..HI.
// Assumes the current value is a legal BCD value inside the range.
module rtc_bcd_field_next #(
    parameter logic [7:0] LO = 8'h00,
    parameter logic [7:0] HI = 8'h59
) (
    input  logic [7:0] cur,
    input  logic       inc,
    output logic [7:0] nxt,
    output logic       wrap
);
    import rtc_cal_pkg::*;

    // Increment with wrap to LO past HI; hold when not incremented.
    always_comb begin
        wrap = inc && (cur == HI);
        if (!inc)      nxt = cur;
        else if (wrap) nxt = LO;
        else           nxt = bcd_inc8(cur);
    end

endmodule

// File: rtl/rtc_hour_next.sv
// Next-value logic for the hours byte in either layout.
// bit 6 = 12-hour mode; in that mode bit 5 = PM and bits 4:0 = BCD 01..12,
// otherwise bits 5:0 = BCD 00..23. Flags midnight when the day must advance.
module rtc_hour_next (
    input  logic [6:0] cur,
    input  logic       inc,
    output logic [6:0] nxt,
    output logic       midnight
);

    logic mode12;
    logic pm;

    assign mode12 = cur[6];
    assign pm     = cur[5];

    // Select the next hour according to the active layout.
    always_comb begin
        nxt      = cur;
        midnight = 1'b0;
        if (inc) begin
            if (mode12) begin
                if (cur[4:0] == 5'h11) begin
                    nxt      = {1'b1, ~pm, 5'h12};
                    midnight = pm;
                end else if (cur[4:0] == 5'h12) begin
                    nxt = {1'b1, pm, 5'h01};
                end else if (cur[3:0] == 4'd9) begin
                    nxt = {1'b1, pm, 1'b1, 4'd0};
                end else begin
                    nxt = {1'b1, pm, cur[4], cur[3:0] + 4'd1};
                end
            end else begin
                if (cur[5:0] == 6'h23) begin
                    nxt      = 7'h00;
                    midnight = 1'b1;
                end else if (cur[3:0] == 4'd9) begin
                    nxt = {1'b0, cur[5:4] + 2'd1, 4'd0};
                end else begin
                    nxt = {1'b0, cur[5:4], cur[3:0] + 4'd1};
                end
            end
        end
    end

endmodule

// File: rtl/rtc_date_next.sv
// Next-value logic for the date of month, with month length and leap February.
// Leap rule: BCD year multiple of four (valid through year 2099); only the
// tens parity (bit 4) and units digit of the year are needed.
module rtc_date_next (
    input  logic [7:0] date,
    input  logic [4:0] month,
    input  logic [4:0] year_lo,
    input  logic       inc,
    output logic [7:0] nxt,
    output logic       month_carry
);
    import rtc_cal_pkg::*;

    logic       leap;
    logic [7:0] last_day;

    // Multiple of four: even tens with units 0/4/8, odd tens with units 2/6.
    always_comb begin
        if (year_lo[4]) leap = (year_lo[3:0] == 4'd2) || (year_lo[3:0] == 4'd6);
        else            leap = (year_lo[3:0] == 4'd0) || (year_lo[3:0] == 4'd4) ||
                               (year_lo[3:0] == 4'd8);
    end

    // Last date of the current month.
    always_comb begin
        case (month)
            5'h02:                      last_day = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

    // Advance the date, wrapping to 01 after the last day.
    always_comb begin
        month_carry = inc && (date == last_day);
        if (!inc)             nxt = date;
        else if (month_carry) nxt = 8'h01;
        else                  nxt = bcd_inc8(date);
    end

endmodule

// File: rtl/rtc_calendar_chain.sv
// Top: BCD clock-calendar register chain with a byte write port, a sub-second
// divider cleared by seconds writes, and a snapshot shadow set for reads.
// Assumes the host writes only legal BCD values; a write beats a same-cycle step.
module rtc_calendar_chain #(
    parameter int FRAC_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frac_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       snap,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    import rtc_cal_pkg::*;

    localparam int DIV_W = (FRAC_PER_SEC > 1) ? $clog2(FRAC_PER_SEC) : 1;

    logic [7:0] r_sec, r_min, r_hour, r_dow, r_date, r_mon, r_year;
    logic [7:0] live  [NUM_REGS];
    logic [7:0] shadow[NUM_REGS];

    logic             wr_hit;
    logic             div_clear;
    logic             sec_step;
    logic [DIV_W-1:0] div_cnt;

    logic [7:0] sec_nxt, min_nxt, dow_nxt, date_nxt, mon_nxt, year_nxt;
    logic [6:0] hour_nxt;
    logic       sec_wrap, min_wrap, midnight, mon_carry, mon_wrap, year_wrap, dow_wrap;

    assign wr_hit    = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
    assign div_clear = wr_en && (wr_addr == ADR_SEC);

    rtc_subsec_div #(.FRAC_PER_SEC(FRAC_PER_SEC), .CNT_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .frac_en  (frac_en),
        .clear    (div_clear),
        .sec_step (sec_step),
        .cnt_o    (div_cnt)
    );

    rtc_bcd_field_next #(.LO(8'h00), .HI(8'h59)) u_sec_nxt (
        .cur(r_sec), .inc(sec_step), .nxt(sec_nxt), .wrap(sec_wrap));

    rtc_bcd_field_next #(.LO(8'h00), .HI(8'h59)) u_min_nxt (
        .cur(r_min), .inc(sec_wrap), .nxt(min_nxt), .wrap(min_wrap));

    rtc_hour_next u_hour_nxt (
        .cur(r_hour[6:0]), .inc(min_wrap), .nxt(hour_nxt), .midnight(midnight));

    rtc_bcd_field_next #(.LO(8'h01), .HI(8'h07)) u_dow_nxt (
        .cur(r_dow), .inc(midnight), .nxt(dow_nxt), .wrap(dow_wrap));

    rtc_date_next u_date_nxt (
        .date(r_date), .month(r_mon[4:0]), .year_lo(r_year[4:0]), .inc(midnight),
        .nxt(date_nxt), .month_carry(mon_carry));

    rtc_bcd_field_next #(.LO(8'h01), .HI(8'h12)) u_mon_nxt (
        .cur({3'b000, r_mon[4:0]}), .inc(mon_carry), .nxt(mon_nxt), .wrap(mon_wrap));

    rtc_bcd_field_next #(.LO(8'h00), .HI(8'h99)) u_year_nxt (
        .cur(r_year), .inc(mon_wrap), .nxt(year_nxt), .wrap(year_wrap));

    // Live registers: reset defaults, then host write, else one second step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_sec  <= reset_val(0);
            r_min  <= reset_val(1);
            r_hour <= reset_val(2);
            r_dow  <= reset_val(3);
            r_date <= reset_val(4);
            r_mon  <= reset_val(5);
            r_year <= reset_val(6);
        end else if (wr_hit) begin
            case (wr_addr)
                ADR_SEC:  r_sec  <= wr_data & wr_mask(0);
                ADR_MIN:  r_min  <= wr_data & wr_mask(1);
                ADR_HOUR: r_hour <= wr_data & wr_mask(2);
                ADR_DOW:  r_dow  <= wr_data & wr_mask(3);
                ADR_DATE: r_date <= wr_data & wr_mask(4);
                ADR_MON:  r_mon  <= wr_data & wr_mask(5);
                default:  r_year <= wr_data & wr_mask(6);
            endcase
        end else if (sec_step) begin
            r_sec  <= sec_nxt;
            r_min  <= min_nxt;
            r_hour <= {1'b0, hour_nxt};
            r_dow  <= dow_nxt;
            r_date <= date_nxt;
            r_mon  <= {r_mon[7] ^ year_wrap, 2'b00, mon_nxt[4:0]};
            r_year <= year_nxt;
        end
    end

    // Gather the live registers in address order for the shadow copy.
    always_comb begin
        live[0] = r_sec;
        live[1] = r_min;
        live[2] = r_hour;
        live[3] = r_dow;
        live[4] = r_date;
        live[5] = r_mon;
        live[6] = r_year;
    end

    // One shadow slot per register, loaded on snap.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)    shadow[g] <= reset_val(g);
            else if (snap) shadow[g] <= live[g];
        end
    end

    // Read mux over the shadow set; unused address reads zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = shadow[i];
        end
    end

endmodule

// File: rtl/rtc_calendar_chain_chk.sv
// Checker: temporal properties of the calendar chain, bound to the top module.
// Assumes it observes the live registers, the shadow set and the divider count.
module rtc_calendar_chain_chk #(
    parameter int NREG  = 7,
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             snap,
    input logic             sec_step,
    input logic [DIV_W-1:0] div_cnt,
    input logic [7:0]       live_sec,
    input logic [7:0]       live_dow,
    input logic [7:0]       live_date,
    input logic [7:0]       live_mon,
    input logic [7:0]       live_year,
    input logic [7:0]       shad_sec,
    input logic [7:0]       shad_year
);

    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr < 3'(NREG));

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (live_sec == 8'h00 && live_dow == 8'h01 && live_date == 8'h01 &&
                          live_mon == 8'h01 && live_year == 8'h00)); // R8

    AST_SEC_WRITE_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (div_cnt == '0)); // R9

    AST_SEC_STILL_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_step && !wr_hit) |=> $stable(live_sec)); // R9

    AST_WRITE_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (live_sec == ($past(wr_data) & 8'h7F))); // R10

    AST_SNAP_COPIES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shad_sec == $past(live_sec))); // R11

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(shad_year)); // R11

    AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_hit) && $past(live_year) == 8'h99 && live_year == 8'h00)
            |-> (live_mon[7] != $past(live_mon[7]))); // R6

    AST_DOW_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_hit) && live_dow != $past(live_dow))
            |-> (live_dow == (($past(live_dow) == 8'h07) ? 8'h01 : $past(live_dow) + 8'h01))); // R7

endmodule

bind rtc_calendar_chain rtc_calendar_chain_chk #(.NREG(7), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .snap      (snap),
    .sec_step  (sec_step),
    .div_cnt   (div_cnt),
    .live_sec  (r_sec),
    .live_dow  (r_dow),
    .live_date (r_date),
    .live_mon  (r_mon),
    .live_year (r_year),
    .shad_sec  (shadow[0]),
    .shad_year (shadow[6])
);

// File: tb/rtc_calendar_chain_bench.sv
`timescale 1ns/100ps
// Bench: behavioural model of the calendar (decoded integers) compared with
// the shadow read port on every clock, plus directed rollover scenarios.
module rtc_calendar_chain_bench;

    localparam int FRAC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frac_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       snap = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit manual = 1'b0;
    bit done   = 1'b0;

    logic [7:0] m_live[7];
    logic [7:0] m_shad[7];
    int         m_div;

    always #2.5 clk = ~clk;

    rtc_calendar_chain #(.FRAC_PER_SEC(FRAC)) u_rtc_calendar_chain (
        .clk(clk), .rst_n(rst_n), .frac_en(frac_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .snap(snap),
        .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] keep_bits(input int a);
        case (a)
            3: return 8'h07;
            4: return 8'h3F;
            5: return 8'h9F;
            6: return 8'hFF;
            default: return 8'h7F;
        endcase
    endfunction

    function automatic int month_days(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // Model reset: both register sets to power-on values.
    task automatic model_reset();
        for (int i = 0; i < 7; i++) begin
            m_live[i] = (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
            m_shad[i] = m_live[i];
        end
        m_div = 0;
    endtask

    // Model one second: decode to integers, count, re-encode.
    task automatic model_second();
        int s, mi, hr, dw, dt, mo, yr, cen;
        bit h12;
        s  = b2i(m_live[0]);
        mi = b2i(m_live[1]);
        h12 = m_live[2][6];
        if (h12) hr = ((int'(m_live[2][4]) * 10 + int'(m_live[2][3:0])) % 12) + (m_live[2][5] ? 12 : 0);
        else     hr = int'(m_live[2][5:4]) * 10 + int'(m_live[2][3:0]);
        dw = b2i(m_live[3]);
        dt = b2i(m_live[4]);
        mo = b2i({3'b000, m_live[5][4:0]});
        cen = int'(m_live[5][7]);
        yr = b2i(m_live[6]);
        s++;
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; hr++; end
        if (hr == 24) begin
            hr = 0;
            dw = (dw % 7) + 1;
            dt++;
            if (dt > month_days(mo, yr)) begin dt = 1; mo++; end
            if (mo == 13) begin mo = 1; yr++; end
            if (yr == 100) begin yr = 0; cen = 1 - cen; end
        end
        m_live[0] = i2b(s);
        m_live[1] = i2b(mi);
        if (h12) m_live[2] = 8'h40 | ((hr >= 12) ? 8'h20 : 8'h00) |
                             i2b((hr % 12 == 0) ? 12 : hr % 12);
        else     m_live[2] = i2b(hr);
        m_live[3] = i2b(dw);
        m_live[4] = i2b(dt);
        m_live[5] = {cen[0], 2'b00, i2b(mo)[4:0]};
        m_live[6] = i2b(yr);
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        logic [7:0] pre[7];
        bit hit, step;
        if (!rst_n) model_reset();
        else begin
            for (int i = 0; i < 7; i++) pre[i] = m_live[i];
            hit  = wr_en && (wr_addr < 3'd7);
            step = frac_en && (m_div == FRAC - 1);
            if (wr_en && wr_addr == 3'd0) m_div = 0;
            else if (frac_en) m_div = (m_div == FRAC - 1) ? 0 : m_div + 1;
            if (hit) m_live[wr_addr] = wr_data & keep_bits(int'(wr_addr));
            else if (step) model_second();
            if (snap) for (int i = 0; i < 7; i++) m_shad[i] = pre[i];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Every clock: rotate the read address and compare against the model shadow (R11).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!manual) rd_addr = (rd_addr == 3'd7) ? 3'd0 : rd_addr + 3'd1;
            #1;
            chk("R11 shadow read vs model", rd_data, (rd_addr == 3'd7) ? 8'h00 : m_shad[rd_addr]);
        end
    end

    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        manual  = 1'b1;
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        manual = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
        frac_en = 1'b0;
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
        wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
    endtask

    task automatic run_secs(input int n);
        @(negedge clk);
        frac_en = 1'b1;
        repeat (n * FRAC) @(negedge clk);
        frac_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset contents
        peek(3'd0, 8'h00, "R8 reset seconds");
        peek(3'd2, 8'h00, "R8 reset hours");
        peek(3'd3, 8'h01, "R8 reset day");
        peek(3'd4, 8'h01, "R8 reset date");
        peek(3'd5, 8'h01, "R8 reset month");
        peek(3'd6, 8'h00, "R8 reset year");
        snap = 1'b1;
        // R9 steps from reset: three seconds
        run_secs(3);
        peek(3'd0, 8'h03, "R9 three seconds counted");
        // R1 digit carry: 09:09:59 -> 09:10:00
        set_time(8'h05, 8'h06, 8'h15, 8'h02, 8'h09, 8'h09, 8'h59);
        run_secs(1);
        peek(3'd0, 8'h00, "R1 seconds wrap");
        peek(3'd1, 8'h10, "R1 minutes digit carry");
        // R2 24h hour digit carry: 09:59:59 -> 10:00:00
        set_time(8'h05, 8'h06, 8'h15, 8'h02, 8'h09, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd2, 8'h10, "R2 hour digit carry");
        // Year-end cascade R2 R4 R6 R7
        set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
        run_secs(2);
        peek(3'd2, 8'h00, "R2 midnight hours");
        peek(3'd3, 8'h01, "R7 day wraps 7 to 1");
        peek(3'd4, 8'h01, "R4 date wraps after 31");
        peek(3'd5, 8'h81, "R6 month wrap and century toggle");
        peek(3'd6, 8'h00, "R6 year wraps 99 to 00");
        // R5 leap and common Februaries
        set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd4, 8'h29, "R5 leap Feb 29 reached");
        set_time(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd4, 8'h01, "R5 leap Feb ends at 29");
        peek(3'd5, 8'h03, "R5 month after leap Feb");
        set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd4, 8'h01, "R5 common Feb ends at 28");
        set_time(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd4, 8'h29, "R5 year 00 is leap");
        // R4 thirty-day month
        set_time(8'h10, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd4, 8'h01, "R4 April ends at 30");
        peek(3'd5, 8'h05, "R4 month after April");
        // R3 12-hour sequence
        set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h51, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd2, 8'h72, "R3 11 AM to 12 PM");
        peek(3'd4, 8'h10, "R3 no date change at noon");
        set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h72, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd2, 8'h61, "R3 12 PM to 1 PM");
        set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h71, 8'h59, 8'h59);
        run_secs(1);
        peek(3'd2, 8'h52, "R3 11 PM to 12 AM");
        peek(3'd4, 8'h11, "R3 date advances at 12 AM");
        peek(3'd3, 8'h04, "R7 day advances at 12 AM");
        // R9 seconds write clears the divider mid-second
        set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h05);
        @(negedge clk); frac_en = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        frac_en = 1'b0;
        peek(3'd0, 8'h30, "R9 no step before full second after clear");
        @(negedge clk); frac_en = 1'b1;
        @(negedge clk); frac_en = 1'b0;
        peek(3'd0, 8'h31, "R9 step after full second");
        // R10 write in the step cycle wins, step discarded
        set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h10);
        @(negedge clk); frac_en = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h22;
        @(negedge clk); wr_en = 1'b0; frac_en = 1'b0;
        peek(3'd0, 8'h10, "R10 colliding step discarded");
        peek(3'd1, 8'h22, "R10 colliding write applied");
        // R10 masks and address 7
        wr(3'd3, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd7, 8'hFF);
        peek(3'd3, 8'h07, "R10 day mask");
        peek(3'd5, 8'h9F, "R10 month mask");
        peek(3'd1, 8'h22, "R10 address 7 write ignored");
        peek(3'd7, 8'h00, "R11 address 7 reads zero");
        // R11 shadow holds without snap
        set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h20);
        @(negedge clk); snap = 1'b0;
        run_secs(2);
        peek(3'd0, 8'h20, "R11 shadow frozen without snap");
        @(negedge clk); snap = 1'b1;
        @(negedge clk); snap = 1'b0;
        peek(3'd0, 8'h22, "R11 snap loads live value");
        snap = 1'b1;
        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule